// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This engine takes received Ethernet frames and places them in host memory. Where each frame goes is set by descriptors, which are 16-byte records that the host keeps in memory. The engine reads each descriptor through a 32-bit memory port and checks that the descriptor has been handed to the engine. It then stores the incoming bytes one at a time into up to two buffers. When the descriptor is finished, it writes a status word back over word 0 of the descriptor. That status word returns the descriptor to the host.

A frame may be longer than the space one descriptor offers. In that case the engine closes the descriptor with a running byte total and carries on in the next one. The last descriptor of the frame carries the final length and the error and filter indications. Descriptors are laid out either as a contiguous ring, which wraps back to the start address, or as a chain, where each descriptor points to the next one. When the engine meets a descriptor the host still holds, it parks and raises a flag. It tries that same descriptor again when the host pulses a poll strobe.

Top module: `rx_desc_engine`

## Requirements
- R1: When `start` is pulsed, the engine reads the descriptor at `ring_base`. A descriptor is read as four word reads, in order, at offsets 0, 4, 8 and 12. Every read is word aligned.
- R2: If bit 31 of word 0 is 0, the engine reads no further words of that descriptor. It asserts `buf_unavail`, issues no memory request and holds `in_ready` low. After a `poll` pulse it reads word 0 of the same descriptor again.
- R3: Frame bytes go to consecutive addresses. They fill buffer 1 (address in word 2, byte count in word 1 bits 12:0), then buffer 2 (address in word 3, count in word 1 bits 28:16). Each byte is one write with `mem_be` = 1 << address[1:0] and the byte repeated on all four lanes.
- R4: A byte count of zero skips that buffer. When word 1 bit 14 (chained) is set, buffer 2 never receives data.
- R5: The status is one full-word write (`mem_be`=1111) to word 0, issued after the descriptor's last data write. Its fields are:
  - bit 31 = 0 (returns the descriptor to the host)
  - bit 30 = filter fail (last descriptor only)
  - bits 29:16 = byte total
  - bit 15 = error summary
  - bit 9 = frame started in this descriptor
  - bit 8 = frame ended in this descriptor
  - all other bits 0
- R6: If both buffers fill before the frame's final byte, the status has bit 8 clear and the running byte total. The frame continues in the next descriptor.
- R7: The next descriptor address is chosen by word 1:
  - bit 15 set (end of ring): the start address.
  - otherwise, bit 14 set (chained): word 3.
  - otherwise: the current address plus 16.
- R8: A memory request keeps its address, data, enables and direction unchanged until `mem_ack`.
- R9: After reset `mem_req`, `in_ready` and `buf_unavail` are low.
- R10: A frame whose final byte carries `in_err` ends with a status that has bits 15 and 8 both set.
- R11: An owned descriptor with no usable buffer is written back at once. Its status carries the running total, with no data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Latch ring_base and begin fetching |
| poll | input | 1 | Retry a descriptor that was held by the host |
| ring_base | input | ADDR_W | Address of the first descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame had an error (with in_eof) |
| in_afail | input | 1 | Frame failed address filtering (with in_eof) |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| buf_unavail | output | 1 | Parked on a host-owned descriptor |

## Verification
The hardest situation to reach is a single frame that runs through every kind of descriptor. The bench builds one 10-byte errored frame that starts in a ring descriptor with a zero buffer-2 count. It continues through a chained descriptor that redirects to a distant address, then through an owned descriptor with no buffers at all. It finishes in the end-of-ring descriptor, using buffer 2 only. That descriptor wraps back to a start descriptor the engine itself has already returned to the host, which forces the parked state. The bench then rewrites that descriptor, issues a poll, and sends a frame that ends exactly on a buffer boundary.

// File: rtl/rx_desc_engine.sv
module rx_desc_engine #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              poll,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              in_afail,
  output logic              in_ready,
  output logic              buf_unavail
);
  localparam int LEN_W = 14;
  localparam int BC_W  = 13;
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(16);

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_STALL, S_SEL, S_DATA, S_WR, S_STAT
  } st_t;

  st_t st;
  logic [ADDR_W-1:0] base_q, desc_q, b1_q, w3_q, cur_q, nxt;
  logic [BC_W-1:0]   bc1_q, bc2_q, rem_q;
  logic              eor_q, chain_q;
  logic [1:0]        bidx_q;
  logic [LEN_W-1:0]  flen_q;
  logic              sof_q, last_q, err_q, afl_q;
  logic [7:0]        byte_q;
  logic [31:0]       stat_w;

  assign stat_w = {1'b0, last_q & afl_q, flen_q, last_q & err_q, 1'b0, 4'b0,
                   sof_q, last_q, 8'b0};
  assign nxt = eor_q ? base_q : (chain_q ? w3_q : desc_q + STRIDE);

  assign mem_req     = (st == S_RD0) || (st == S_RD1) || (st == S_RD2) ||
                       (st == S_RD3) || (st == S_WR) || (st == S_STAT);
  assign mem_we      = (st == S_WR) || (st == S_STAT);
  assign in_ready    = (st == S_DATA);
  assign buf_unavail = (st == S_STALL);

  always_comb begin
    mem_addr  = desc_q;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (st)
      S_RD1:  mem_addr = desc_q + ADDR_W'(4);
      S_RD2:  mem_addr = desc_q + ADDR_W'(8);
      S_RD3:  mem_addr = desc_q + ADDR_W'(12);
      S_WR: begin
        mem_addr  = cur_q;
        mem_wdata = {4{byte_q}};
        mem_be    = 4'b0001 << cur_q[1:0];
      end
      S_STAT: mem_wdata = stat_w;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0; desc_q <= '0; b1_q <= '0; w3_q <= '0; cur_q <= '0;
      bc1_q <= '0; bc2_q <= '0; rem_q <= '0;
      eor_q <= 1'b0; chain_q <= 1'b0; bidx_q <= '0;
      flen_q <= '0; sof_q <= 1'b0; last_q <= 1'b0; err_q <= 1'b0; afl_q <= 1'b0;
      byte_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= ring_base;
          desc_q <= ring_base;
          st     <= S_RD0;
        end
        S_RD0: if (mem_ack) st <= mem_rdata[31] ? S_RD1 : S_STALL;
        S_RD1: if (mem_ack) begin
          bc1_q   <= mem_rdata[BC_W-1:0];
          bc2_q   <= mem_rdata[16 +: BC_W];
          eor_q   <= mem_rdata[15];
          chain_q <= mem_rdata[14];
          st      <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          b1_q <= mem_rdata[ADDR_W-1:0];
          st   <= S_RD3;
        end
        S_RD3: if (mem_ack) begin
          w3_q   <= mem_rdata[ADDR_W-1:0];
          bidx_q <= 2'd0;
          st     <= S_SEL;
        end
        S_STALL: if (poll) st <= S_RD0;
        S_SEL: begin
          case (bidx_q)
            2'd0: begin
              bidx_q <= 2'd1;
              if (bc1_q != '0) begin
                cur_q <= b1_q; rem_q <= bc1_q; st <= S_DATA;
              end
            end
            2'd1: begin
              bidx_q <= 2'd2;
              if (!chain_q && bc2_q != '0) begin
                cur_q <= w3_q; rem_q <= bc2_q; st <= S_DATA;
              end
            end
            default: st <= S_STAT;
          endcase
        end
        S_DATA: if (in_valid) begin
          byte_q <= in_data;
          if (in_sof) begin
            sof_q  <= 1'b1;
            flen_q <= '0;
          end
          if (in_eof) begin
            last_q <= 1'b1;
            err_q  <= in_err;
            afl_q  <= in_afail;
          end
          st <= S_WR;
        end
        S_WR: if (mem_ack) begin
          flen_q <= flen_q + LEN_W'(1);
          cur_q  <= cur_q + ADDR_W'(1);
          rem_q  <= rem_q - BC_W'(1);
          if (last_q)                 st <= S_STAT;
          else if (rem_q == BC_W'(1)) st <= S_SEL;
          else                        st <= S_DATA;
        end
        S_STAT: if (mem_ack) begin
          desc_q <= nxt;
          sof_q  <= 1'b0;
          if (last_q) begin
            last_q <= 1'b0;
            err_q  <= 1'b0;
            afl_q  <= 1'b0;
            flen_q <= '0;
          end
          st <= S_RD0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                            && $stable(mem_be) && $stable(mem_we));
  // R1
  read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[1:0] == 2'b00);
  // R2
  park_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_unavail) |-> $past(mem_req && !mem_we && mem_ack && !mem_rdata[31]));
  // R2
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail && !poll |=> buf_unavail);
  // R5
  stat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be == 4'hF |-> !mem_wdata[31]);
  // R10
  err_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be == 4'hF && mem_wdata[15] |-> mem_wdata[8]);
  // R3
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be != 4'hF |-> $onehot(mem_be));
endmodule

// File: tb/rx_desc_engine_test.sv
module rx_desc_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, poll = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic [3:0] mem_be;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0, in_afail = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_ready, buf_unavail;

  always #10 clk = ~clk;

  rx_desc_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll(poll), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_afail(in_afail), .in_ready(in_ready), .buf_unavail(buf_unavail)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] mem [0:255];
  bit          exp_we[$];
  logic [31:0] exp_addr[$], exp_data[$];
  logic [3:0]  exp_be[$];
  string       exp_tag[$];

  task automatic push(input bit we, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d, input string tag);
    exp_we.push_back(we); exp_addr.push_back(a); exp_be.push_back(be);
    exp_data.push_back(d); exp_tag.push_back(tag);
  endtask

  // memory responder: variable latency, every transaction compared with the model
  initial begin
    int wcnt = 0, lat = 0;
    bit pend = 1'b0;
    logic [31:0] raddr = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0; pend = 1'b0;
      end else if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!pend) begin
          pend = 1'b1; raddr = mem_addr; wcnt = lat; lat = (lat + 1) % 3;
        end
        if (wcnt > 0) wcnt--;
        else begin
          chk(mem_addr == raddr, "R8", "address moved before ack", mem_addr, raddr);
          if (exp_addr.size() == 0) begin
            chk(1'b0, "R1", "unexpected memory access", mem_addr, 32'hFFFF_FFFF);
          end else begin
            bit ew; logic [31:0] ea, ed; logic [3:0] eb; string et;
            ew = exp_we.pop_front(); ea = exp_addr.pop_front(); eb = exp_be.pop_front();
            ed = exp_data.pop_front(); et = exp_tag.pop_front();
            chk(mem_addr == ea, et, "address", mem_addr, ea);
            chk(mem_we == ew, et, "direction", 32'(mem_we), 32'(ew));
            if (ew) begin
              chk(mem_be == eb, et, "byte enables", 32'(mem_be), 32'(eb));
              chk(mem_wdata == ed, et, "write data", mem_wdata, ed);
            end
          end
          if (mem_addr < 32'h400) begin
            if (mem_we) begin
              for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            end else mem_rdata = mem[mem_addr[9:2]];
          end
          mem_ack = 1'b1; pend = 1'b0;
        end
      end
    end
  end

  // descriptor table known to the bench
  logic [31:0] d_addr[5], d_b1[5], d_b2[5];
  int d_bc1[5], d_bc2[5];
  bit d_chain[5], d_eor[5], own_m[5];

  task automatic set_desc(input int i);
    mem[d_addr[i][9:2]]     = {own_m[i], 31'b0};
    mem[d_addr[i][9:2] + 1] = {3'b0, 13'(d_bc2[i]), d_eor[i], d_chain[i], 1'b0, 13'(d_bc1[i])};
    mem[d_addr[i][9:2] + 2] = d_b1[i];
    mem[d_addr[i][9:2] + 3] = d_b2[i];
  endtask

  // behavioural reference model
  int midx = 0, mlen = 0, mbidx = 0, mrem = 0;
  bit msof = 1'b0;
  logic [31:0] maddr = 0;

  function automatic logic [31:0] stat(input int len, input bit first, input bit last,
                                       input bit err, input bit af);
    return {1'b0, last & af, 14'(len), last & err, 1'b0, 4'b0, first, last, 8'b0};
  endfunction

  task automatic m_sel(output bit got);
    got = 1'b0;
    if (mbidx == 0) begin
      mbidx = 1;
      if (d_bc1[midx] != 0) begin maddr = d_b1[midx]; mrem = d_bc1[midx]; got = 1'b1; return; end
    end
    if (mbidx == 1) begin
      mbidx = 2;
      if (!d_chain[midx] && d_bc2[midx] != 0) begin
        maddr = d_b2[midx]; mrem = d_bc2[midx]; got = 1'b1;
      end
    end
  endtask

  task automatic m_fetch(input string rtag);
    string t;
    bit got;
    t = rtag;
    forever begin
      push(1'b0, d_addr[midx], 4'h0, 0, t);
      if (!own_m[midx]) return;
      for (int w = 1; w < 4; w++) push(1'b0, d_addr[midx] + 32'(4 * w), 4'h0, 0, t);
      mbidx = 0;
      m_sel(got);
      if (got) return;
      push(1'b1, d_addr[midx], 4'hF, stat(mlen, msof, 1'b0, 1'b0, 1'b0), "R11");
      own_m[midx] = 1'b0; msof = 1'b0;
      t = (d_eor[midx] || d_chain[midx]) ? "R7" : "R1";
      midx = d_eor[midx] ? 0 : midx + 1;
    end
  endtask

  task automatic m_close(input bit last, input bit err, input bit af, input string tag);
    string t;
    push(1'b1, d_addr[midx], 4'hF, stat(mlen, msof, last, err, af), tag);
    own_m[midx] = 1'b0; msof = 1'b0;
    if (last) mlen = 0;
    t = (d_eor[midx] || d_chain[midx]) ? "R7" : "R1";
    midx = d_eor[midx] ? 0 : midx + 1;
    m_fetch(t);
  endtask

  function automatic logic [7:0] fbyte(input int k, input int j);
    return 8'(k * 40 + j + 1);
  endfunction

  task automatic model_frame(input int k, input int len, input bit err, input bit af);
    bit got;
    for (int j = 0; j < len; j++) begin
      string dt;
      dt = (d_chain[midx] || d_bc1[midx] == 0) ? "R4" : "R3";
      push(1'b1, maddr, 4'b0001 << maddr[1:0], {4{fbyte(k, j)}}, dt);
      mlen++;
      if (j == 0) msof = 1'b1;
      maddr++; mrem--;
      if (j == len - 1) m_close(1'b1, err, af, err ? "R10" : "R5");
      else if (mrem == 0) begin
        m_sel(got);
        if (!got) m_close(1'b0, 1'b0, 1'b0, "R6");
      end
    end
  endtask

  task automatic send_frame(input int k, input int len, input bit err, input bit af);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fbyte(k, j);
      in_sof = (j == 0); in_eof = (j == len - 1);
      in_err = (j == len - 1) && err; in_afail = (j == len - 1) && af;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_afail = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_addr.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    chk(exp_addr.size() == 0, tag, "model transactions left", 32'(exp_addr.size()), 0);
  endtask

  task automatic expect_park();
    int n = 0, seen = 0;
    while (!buf_unavail && n < 200) begin @(negedge clk); n++; end
    chk(buf_unavail == 1'b1, "R2", "buf_unavail", 32'(buf_unavail), 1);
    chk(in_ready == 1'b0, "R2", "in_ready while parked", 32'(in_ready), 0);
    repeat (20) begin @(negedge clk); if (mem_req) seen++; end
    chk(seen == 0, "R2", "requests while parked", 32'(seen), 0);
    chk(buf_unavail == 1'b1, "R2", "still parked without poll", 32'(buf_unavail), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'h0;
    d_addr = '{32'h000, 32'h010, 32'h020, 32'h080, 32'h090};
    d_b1   = '{32'h100, 32'h181, 32'h1C2, 32'h0, 32'h0};
    d_b2   = '{32'h140, 32'h0, 32'h080, 32'h0, 32'h200};
    d_bc1  = '{6, 5, 3, 0, 0};
    d_bc2  = '{4, 0, 7, 0, 4};
    d_chain = '{0, 0, 1, 0, 0};
    d_eor   = '{0, 0, 0, 0, 1};
    own_m   = '{1, 1, 1, 1, 1};
    for (int i = 0; i < 5; i++) set_desc(i);

    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mem_req == 1'b0, "R9", "mem_req after reset", 32'(mem_req), 0);
    chk(in_ready == 1'b0, "R9", "in_ready after reset", 32'(in_ready), 0);
    chk(buf_unavail == 1'b0, "R9", "buf_unavail after reset", 32'(buf_unavail), 0);
    rst_n = 1'b1;
    @(negedge clk);

    midx = 0;
    m_fetch("R1");
    start = 1'b1; @(negedge clk); start = 1'b0;

    // frame 1 spills from buffer 1 into buffer 2
    model_frame(1, 8, 1'b0, 1'b0);
    send_frame(1, 8, 1'b0, 1'b0);
    drain("R3");

    // frame 2 crosses ring, chained, empty and end-of-ring descriptors
    model_frame(2, 10, 1'b1, 1'b1);
    send_frame(2, 10, 1'b1, 1'b1);
    drain("R6");
    expect_park();
    chk(mem[32'h090 >> 2] == stat(10, 0, 1, 1, 1), "R10", "final status in memory",
        mem[32'h090 >> 2], stat(10, 0, 1, 1, 1));
    chk(mem[32'h180 >> 2][15:8] == fbyte(2, 0), "R3", "unaligned first byte stored",
        32'(mem[32'h180 >> 2][15:8]), 32'(fbyte(2, 0)));

    // host returns descriptor 0 and polls
    own_m[0] = 1'b1; set_desc(0);
    m_fetch("R2");
    @(negedge clk); poll = 1'b1; @(negedge clk); poll = 1'b0;
    // frame 3 ends exactly on the buffer 1 boundary
    model_frame(3, 6, 1'b0, 1'b1);
    send_frame(3, 6, 1'b0, 1'b1);
    drain("R5");
    expect_park();
    chk(mem[0] == stat(6, 1, 1, 0, 1), "R5", "status of boundary frame",
        mem[0], stat(6, 1, 1, 0, 1));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule